// File: doc/BRIEF.md
# Sixteen-Bit Two-Tier Lookahead Adder

This block adds two 16-bit operands and an incoming carry, producing a 16-bit sum and a carry-out. It is purely combinational: results follow the operands with no clock, no register and no reset. It is meant to sit inside a larger datapath wherever a short carry path matters more than area.

The operands are split into four nibble-wide groups. In each bit, a generate term is the AND of the two operand bits and a propagate term is their OR. Inside a group, every bit's carry is formed directly from the group's incoming carry and these terms as a flat sum of products, with nothing rippling from bit to bit. Each group also condenses its bits into one group propagate (the AND of its four bit propagates) and one group generate. A second tier applies the same flat sum-of-products rule to the four group pairs and the adder's carry-in. This yields the carry into groups one to three and the final carry-out. The OR-form propagate is used only for carries. Each sum bit is the XOR of the two operand bits and that bit's carry.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of the arithmetic value `a_i + b_i + c0_i`.
- R2: `cout_o` equals bit 16 of `a_i + b_i + c0_i`, computed with 17-bit precision.
- R3: When every bit position has at least one operand bit set (all group propagates true) and `c0_i` is 1, `cout_o` is 1. For `a_i = ~b_i` with `c0_i = 1` this gives `sum_o = 0x0000`.
- R4: The carry entering group k (bits 4k to 4k+3, k = 1..3) equals bit 4k of the sum of the operands masked to bits below 4k plus `c0_i`. At the ports it is seen as `sum_o[4k] ^ a_i[4k] ^ b_i[4k]`.
- R5: A group whose group generate is true passes a carry of 1 into the next group, whatever `c0_i` and the lower bits are. An example is a nibble with `a = b = 0xF`.
- R6: Raising `c0_i` from 0 to 1 with the same operands raises the 17-bit result `{cout_o, sum_o}` by exactly one, modulo 2^17.
- R7: Outputs depend on the present inputs only. They are valid within the same cycle after an input change, with no clock edge needed.
- R8: Exchanging `a_i` and `b_i` leaves `sum_o` and `cout_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c0_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
Every result of this block is due zero cycles after its stimulus, because there is no register between the operands and the outputs. The bench changes the inputs just after a falling clock edge and samples one nanosecond later, before the next rising edge. This means no result depends on an edge. The group carries are recovered at the ports from sum bits 4, 8 and 12 in that same sample, and compared against masked arithmetic sums computed in the bench.

// File: rtl/cla16_pkg.sv
`timescale 1ns/1ps
package cla16_pkg;

  // Widest flat lookahead supported by the helpers below
  localparam int LA_MAX = 8;

  typedef struct packed {
    logic prop;
    logic gen;
  } grp_pg_t;

  // Carry into position k of a lookahead span, as a flat sum of products:
  // cin & p[0..k-1]  |  OR over j<k of ( g[j] & p[j+1..k-1] )
  function automatic logic la_carry(input logic [LA_MAX-1:0] g,
                                    input logic [LA_MAX-1:0] p,
                                    input logic cin,
                                    input int k);
    logic res;
    logic term;
    res = cin;
    for (int i = 0; i < LA_MAX; i++) begin
      if (i < k) res = res & p[i];
    end
    for (int j = 0; j < LA_MAX; j++) begin
      if (j < k) begin
        term = g[j];
        for (int i = 0; i < LA_MAX; i++) begin
          if (i > j && i < k) term = term & p[i];
        end
        res = res | term;
      end
    end
    return res;
  endfunction

  // Condense n bits into a group propagate / generate pair
  function automatic grp_pg_t la_group_pg(input logic [LA_MAX-1:0] g,
                                          input logic [LA_MAX-1:0] p,
                                          input int n);
    grp_pg_t r;
    r.prop = 1'b1;
    for (int i = 0; i < LA_MAX; i++) begin
      if (i < n) r.prop = r.prop & p[i];
    end
    r.gen = la_carry(g, p, 1'b0, n);
    return r;
  endfunction

  function automatic logic sum_bit(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
`timescale 1ns/1ps
module cla_bit_pg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] | b_i[i];
  end
endmodule

// File: rtl/cla_group.sv
`timescale 1ns/1ps
module cla_group
  import cla16_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          grp_prop_o,
  output logic          grp_gen_o
);
  logic [GW-1:0] gen_w;
  logic [GW-1:0] prop_w;
  logic [GW-1:0] carry_w;
  grp_pg_t       pg_w;

  cla_bit_pg #(.W(GW)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (gen_w),
    .prop_o (prop_w)
  );

  // First tier: every bit carry straight from the group carry-in
  for (genvar k = 0; k < GW; k++) begin : g_carry
    assign carry_w[k] = la_carry(LA_MAX'(gen_w), LA_MAX'(prop_w), cin_i, k);
    assign sum_o[k]   = sum_bit(a_i[k], b_i[k], carry_w[k]);
  end

  assign pg_w       = la_group_pg(LA_MAX'(gen_w), LA_MAX'(prop_w), GW);
  assign grp_prop_o = pg_w.prop;
  assign grp_gen_o  = pg_w.gen;
endmodule

// File: rtl/cla_lookahead_unit.sv
`timescale 1ns/1ps
module cla_lookahead_unit
  import cla16_pkg::*;
#(
  parameter int NG = 4
) (
  input  logic [NG-1:0] grp_prop_i,
  input  logic [NG-1:0] grp_gen_i,
  input  logic          cin_i,
  output logic [NG:0]   grp_carry_o
);
  // Second tier: carry into each group and out of the top one
  for (genvar k = 0; k <= NG; k++) begin : g_gc
    assign grp_carry_o[k] = la_carry(LA_MAX'(grp_gen_i), LA_MAX'(grp_prop_i), cin_i, k);
  end
endmodule

// File: rtl/cla16_adder.sv
`timescale 1ns/1ps
module cla16_adder #(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 4
) (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        c0_i,
  output logic [15:0] sum_o,
  output logic        cout_o
);
  localparam int WIDTH = GROUP_W * NUM_GROUPS;

  // Named internal events, observed by the bound checker
  logic [NUM_GROUPS-1:0] grp_prop;
  logic [NUM_GROUPS-1:0] grp_gen;
  logic [NUM_GROUPS:0]   grp_cin;
  logic [WIDTH-1:0]      a_w;
  logic [WIDTH-1:0]      b_w;
  logic [WIDTH-1:0]      sum_w;

  assign a_w = a_i;
  assign b_w = b_i;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    cla_group #(.GW(GROUP_W)) u_grp (
      .a_i        (a_w[k*GROUP_W +: GROUP_W]),
      .b_i        (b_w[k*GROUP_W +: GROUP_W]),
      .cin_i      (grp_cin[k]),
      .sum_o      (sum_w[k*GROUP_W +: GROUP_W]),
      .grp_prop_o (grp_prop[k]),
      .grp_gen_o  (grp_gen[k])
    );
  end

  cla_lookahead_unit #(.NG(NUM_GROUPS)) u_la (
    .grp_prop_i  (grp_prop),
    .grp_gen_i   (grp_gen),
    .cin_i       (c0_i),
    .grp_carry_o (grp_cin)
  );

  assign sum_o  = sum_w;
  assign cout_o = grp_cin[NUM_GROUPS];
endmodule

// File: rtl/cla16_adder_chk.sv
`timescale 1ns/1ps
module cla16_adder_chk #(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 4
) (
  input logic [15:0]           a_i,
  input logic [15:0]           b_i,
  input logic                  c0_i,
  input logic [15:0]           sum_o,
  input logic                  cout_o,
  input logic [NUM_GROUPS-1:0] grp_prop,
  input logic [NUM_GROUPS-1:0] grp_gen,
  input logic [NUM_GROUPS:0]   grp_cin
);
  localparam int WIDTH = GROUP_W * NUM_GROUPS;

  logic [WIDTH:0] full_ref;
  assign full_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c0_i};

  always_comb begin
    a_r1_sum_value: assert (sum_o == full_ref[WIDTH-1:0])
      else $error("R1 sum mismatch");
    a_r2_cout_value: assert (cout_o == full_ref[WIDTH])
      else $error("R2 carry-out mismatch");
    a_r3_full_propagate: assert (!((&grp_prop) && c0_i) || cout_o)
      else $error("R3 propagate chain dropped carry");
  end

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_chk
    localparam logic [WIDTH:0] MASK = ((WIDTH+1)'(1) << (k*GROUP_W)) - (WIDTH+1)'(1);
    logic [WIDTH:0] lo_ref;
    assign lo_ref = ({1'b0, a_i} & MASK) + ({1'b0, b_i} & MASK) + {{WIDTH{1'b0}}, c0_i};
    always_comb begin
      a_r4_group_carry: assert (grp_cin[k] == lo_ref[k*GROUP_W])
        else $error("R4 group carry mismatch");
      a_r5_gen_forces_carry: assert (!grp_gen[k] || grp_cin[k+1])
        else $error("R5 generate did not force carry");
    end
  end
endmodule

bind cla16_adder cla16_adder_chk #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .c0_i     (c0_i),
  .sum_o    (sum_o),
  .cout_o   (cout_o),
  .grp_prop (grp_prop),
  .grp_gen  (grp_gen),
  .grp_cin  (grp_cin)
);

// File: tb/cla16_adder_tb.sv
`timescale 1ns/1ps
module cla16_adder_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a_i, b_i, sum_o;
  logic        c0_i, cout_o;
  int n_chk = 0;
  int n_bad = 0;

  cla16_adder dut_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .c0_i   (c0_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

  task automatic expect_eq(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Drive after a falling edge, sample 1 ns later: no rising edge in between (R7)
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(negedge clk);
    a_i = a; b_i = b; c0_i = c;
    #1;
  endtask

  task automatic check_vec(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] exp;
    apply(a, b, c);
    exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
    expect_eq("R1 sum", 32'(sum_o), 32'(exp[15:0]));
    expect_eq("R2 cout", 32'(cout_o), 32'(exp[16]));
    for (int k = 1; k < 4; k++) begin
      logic [16:0] m, lo;
      m  = (17'd1 << (4*k)) - 17'd1;
      lo = ({1'b0, a} & m) + ({1'b0, b} & m) + {16'd0, c};
      expect_eq("R4 group carry", 32'(sum_o[4*k] ^ a[4*k] ^ b[4*k]), 32'(lo[4*k]));
    end
  endtask

  initial begin
    logic [16:0] r0, r1, rs;
    logic [15:0] ra, rb;
    a_i = '0; b_i = '0; c0_i = 1'b0;

    // R7: idle inputs give a zero result at once
    apply(16'h0000, 16'h0000, 1'b0);
    expect_eq("R7 zero inputs", 32'({cout_o, sum_o}), 32'h0);

    // Exhaustive low six bits of each operand, both carry-in values
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        for (int c = 0; c < 2; c++)
          check_vec(16'(x), 16'(y), 1'(c));

    // Exhaustive nibble per group, surroundings set to propagate
    for (int k = 0; k < 4; k++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++)
            check_vec((16'hFFFF & ~(16'hF << (4*k))) | (16'(x) << (4*k)),
                      16'(y) << (4*k), 1'(c));

    // R3: full propagate chain
    apply(16'hFFFF, 16'h0000, 1'b1);
    expect_eq("R3 ffff+0+1", 32'({cout_o, sum_o}), 32'h10000);
    apply(16'h5555, 16'hAAAA, 1'b1);
    expect_eq("R3 5555+aaaa+1", 32'({cout_o, sum_o}), 32'h10000);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    expect_eq("R2 ffff+ffff+1", 32'({cout_o, sum_o}), 32'h1FFFF);
    apply(16'h8000, 16'h8000, 1'b0);
    expect_eq("R2 8000+8000", 32'({cout_o, sum_o}), 32'h10000);

    // R5: a generating group forces a carry into the next one
    apply(16'h00F0, 16'h00F0, 1'b0);
    expect_eq("R5 group1 generate", 32'(sum_o[8] ^ a_i[8] ^ b_i[8]), 32'h1);
    apply(16'h0F00, 16'h0F00, 1'b1);
    expect_eq("R5 group2 generate", 32'(sum_o[12] ^ a_i[12] ^ b_i[12]), 32'h1);
    apply(16'hF000, 16'hF000, 1'b0);
    expect_eq("R5 group3 generate", 32'(cout_o), 32'h1);

    // Random vectors, with R6 and R8 relations
    for (int n = 0; n < 3000; n++) begin
      ra = 16'($urandom); rb = 16'($urandom);
      check_vec(ra, rb, 1'b0);
      r0 = {cout_o, sum_o};
      apply(ra, rb, 1'b1);
      r1 = {cout_o, sum_o};
      expect_eq("R6 carry-in adds one", 32'(r1), 32'(r0 + 17'd1));
      apply(rb, ra, 1'b1);
      rs = {cout_o, sum_o};
      expect_eq("R8 operand swap", 32'(rs), 32'(r1));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule